// File: doc/BRIEF.md
# Write-Protected In-System Programming Control Register

This block holds the control byte that steers in-system reprogramming of on-chip program memory. A processor-side special-function-register bus can write two locations: a key register and the control register. The control register refuses every write until software has written the two key bytes 87h and 59h to the key register, in that order. Any other byte written to the key register closes the register again. While open, the control register stays open across any number of writes.

The control byte drives three static outputs: a programming-enable flag, a boot-bank select and an auxiliary-RAM enable. When the programming-enable flag is set and the core signals a wake-up from idle, the block raises a one-cycle request to enter programming mode, which also tells the core to clear its program counter before fetching from the loader bank. Writing the control byte with bits 0, 1 and 7 all set fires a one-cycle software reset pulse and returns every register in the block to its reset state. The control byte can be read back over the same bus.

Top module: `isp_ctl_reg`

## Requirements
- R1: After reset, and whenever the key state is not open, a write to the control register address changes no output and no readback bit.
- R2: The control register opens only after a key-register write of 87h immediately followed (among key-register writes) by a write of 59h; a key write of 87h restarts the sequence and closes an open register; a key write of any value other than 87h or 59h closes it; 59h keeps an open register open and leaves a closed one closed; the key state takes effect on the cycle after the key write.
- R3: `prog_en` equals bit 0 of the last accepted control write, from the cycle after that write; it is 0 after reset.
- R4: `boot_sel` equals bit 1 of the last accepted control write (0: loader runs from the main bank and the small bank is the target; 1: loader runs from the small bank and the main bank is the target); 0 after reset.
- R5: `auxram_en` equals bit 4 of the last accepted control write; 0 after reset.
- R6: An accepted control write with bits 0, 1 and 7 all 1 makes `swrst_pulse` high for exactly the next cycle, and in that cycle all outputs and the key state are already at their reset values.
- R7: `prog_entry` is high for one cycle, the cycle after a cycle in which `idle_wake` is high while `prog_en` is 1; it marks programming-mode entry and a program-counter clear. The block then counts as running in programming mode until reset.
- R8: With `bus_addr` at the control address (BFh), `bus_rdata` shows bit 0 = programming enable, bit 1 = boot select, bit 4 = auxiliary-RAM enable, bit 7 = 1 exactly when programming mode has been entered and boot select is 1; every other address reads 00h.
- R9: Bits 2, 3, 5 and 6 of the control register are never stored and always read 0.
- R10: When `idle_wake` and an accepted control write fall in the same cycle, the entry decision uses the programming-enable value held before the write; when the write is a software-reset pattern, the reset wins and no entry request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| idle_wake | input | 1 | One-cycle wake-from-idle event from the core |
| prog_en | output | 1 | Programming enable (control bit 0) |
| boot_sel | output | 1 | Boot-bank select (control bit 1) |
| auxram_en | output | 1 | Auxiliary-RAM enable (control bit 4) |
| prog_entry | output | 1 | One-cycle programming-mode entry and PC-clear request |
| swrst_pulse | output | 1 | One-cycle software reset request |

## Verification
A wake from idle and an accepted control write can land on the same clock edge, so the entry decision and the register update race each other. The bench provokes this twice: once with a write that clears the programming enable while a wake arrives, expecting the entry request to follow the old enable, and once with a software-reset pattern during a wake, expecting the reset pulse and no entry. A behavioural model updated on every edge judges both, and the outputs and readback are compared to it on every cycle.

// File: rtl/isp_ctl_pkg.sv
// Shared definitions for the protected programming control register.
// Assumes an 8-bit control byte; field positions are decoded by the core.
package isp_ctl_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    localparam int unsigned FLD_PEN  = 0;
    localparam int unsigned FLD_SEL  = 1;
    localparam int unsigned FLD_AUX  = 4;
    localparam int unsigned FLD_BOOT = 7;

endpackage

// File: rtl/isp_key_fsm.sv
// Key-sequence tracker: opens write access after KEY_A then KEY_B on the
// key register; any other key value closes it. Assumes one write per cycle.
module isp_key_fsm
    import isp_ctl_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_A = 8'h87,
    parameter logic [DATA_W-1:0] KEY_B = 8'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_data_i,
    output logic              open_o
);

    key_state_e state_q, state_d;

    // Next key state from the written byte.
    always_comb begin
        state_d = state_q;
        if (key_wr_i) begin
            if (key_data_i == KEY_A) begin
                state_d = KS_HALF;
            end else if (key_data_i == KEY_B) begin
                state_d = (state_q == KS_LOCKED) ? KS_LOCKED : KS_OPEN;
            end else begin
                state_d = KS_LOCKED;
            end
        end
    end

    // Key state register, cleared by reset or software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            state_q <= KS_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    assign open_o = (state_q == KS_OPEN);

endmodule

// File: rtl/isp_ctl_bits.sv
// Control field storage and software reset generation. Assumes wr_i is
// already qualified by the key state.
module isp_ctl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic pen_d,
    input  logic sel_d,
    input  logic aux_d,
    input  logic top_d,
    output logic pen_o,
    output logic sel_o,
    output logic aux_o,
    output logic fire_o,
    output logic pulse_o
);

    assign fire_o = wr_i && pen_d && sel_d && top_d;

    // Store fields on an accepted write; a reset pattern clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || fire_o) begin
            pen_o <= 1'b0;
            sel_o <= 1'b0;
            aux_o <= 1'b0;
        end else if (wr_i) begin
            pen_o <= pen_d;
            sel_o <= sel_d;
            aux_o <= aux_d;
        end
    end

    // One-cycle software reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= fire_o;
        end
    end

endmodule

// File: rtl/isp_wake_ctl.sv
// Programming-mode entry on wake from idle. Uses the enable value held
// before any same-cycle write; a software reset suppresses entry.
module isp_wake_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic wake_i,
    input  logic pen_i,
    output logic entry_o,
    output logic active_o
);

    // Entry pulse and sticky programming-mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            entry_o  <= 1'b0;
            active_o <= 1'b0;
        end else begin
            entry_o <= wake_i && pen_i;
            if (wake_i && pen_i) begin
                active_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/isp_ctl_reg.sv
// Protected in-system programming control register: key register plus
// control register on a byte-wide register bus, with combinational readback.
module isp_ctl_reg
    import isp_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hF6,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hBF,
    parameter logic [DATA_W-1:0] KEY_A = 8'h87,
    parameter logic [DATA_W-1:0] KEY_B = 8'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              idle_wake,
    output logic              prog_en,
    output logic              boot_sel,
    output logic              auxram_en,
    output logic              prog_entry,
    output logic              swrst_pulse
);

    logic key_wr, ctl_wr, ul_open, sw_fire, prog_active;
    logic [DATA_W-1:0] ctl_view;

    assign key_wr = bus_wr && (bus_addr == KEY_ADDR);
    assign ctl_wr = bus_wr && (bus_addr == CTL_ADDR) && ul_open;

    isp_key_fsm #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (sw_fire),
        .key_wr_i   (key_wr),
        .key_data_i (bus_wdata),
        .open_o     (ul_open)
    );

    isp_ctl_bits u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .pen_d   (bus_wdata[FLD_PEN]),
        .sel_d   (bus_wdata[FLD_SEL]),
        .aux_d   (bus_wdata[FLD_AUX]),
        .top_d   (bus_wdata[FLD_BOOT]),
        .pen_o   (prog_en),
        .sel_o   (boot_sel),
        .aux_o   (auxram_en),
        .fire_o  (sw_fire),
        .pulse_o (swrst_pulse)
    );

    isp_wake_ctl u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (sw_fire),
        .wake_i   (idle_wake),
        .pen_i    (prog_en),
        .entry_o  (prog_entry),
        .active_o (prog_active)
    );

    // Readback image of the control register.
    always_comb begin
        ctl_view           = '0;
        ctl_view[FLD_PEN]  = prog_en;
        ctl_view[FLD_SEL]  = boot_sel;
        ctl_view[FLD_AUX]  = auxram_en;
        ctl_view[FLD_BOOT] = prog_active && boot_sel;
    end

    // Address-selected read data.
    assign bus_rdata = (bus_addr == CTL_ADDR) ? ctl_view : '0;

endmodule

// File: rtl/isp_ctl_reg_chk.sv
// Property checker for isp_ctl_reg, attached by bind.
module isp_ctl_reg_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hF6,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hBF,
    parameter logic [DATA_W-1:0] KEY_A = 8'h87,
    parameter logic [DATA_W-1:0] KEY_B = 8'h59
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              idle_wake,
    input logic              prog_en,
    input logic              boot_sel,
    input logic              auxram_en,
    input logic              prog_entry,
    input logic              swrst_pulse,
    input logic              ul_open
);

    logic ctl_hit, key_hit, rst_pat;
    assign ctl_hit = bus_wr && (bus_addr == CTL_ADDR);
    assign key_hit = bus_wr && (bus_addr == KEY_ADDR);
    assign rst_pat = bus_wdata[0] && bus_wdata[1] && bus_wdata[7];

    a_r1_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && !ul_open) |=> $stable({prog_en, boot_sel, auxram_en}));

    a_r2_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ul_open) |-> $past(key_hit && bus_wdata == KEY_B));

    a_r2_close_other: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hit && bus_wdata != KEY_A && bus_wdata != KEY_B) |=> !ul_open);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_pulse |=> !swrst_pulse);

    a_r6_clean_state: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_pulse |-> (!prog_en && !boot_sel && !auxram_en && !ul_open && !prog_entry));

    a_r7_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        prog_entry |-> $past(prog_en && idle_wake));

    a_r10_old_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wake && prog_en && !(ctl_hit && ul_open && rst_pat)) |=> prog_entry);

endmodule

bind isp_ctl_reg isp_ctl_reg_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .CTL_ADDR(CTL_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .idle_wake(idle_wake), .prog_en(prog_en),
    .boot_sel(boot_sel), .auxram_en(auxram_en), .prog_entry(prog_entry),
    .swrst_pulse(swrst_pulse), .ul_open(ul_open)
);

// File: tb/test_isp_ctl_reg.sv
`timescale 1ns/1ps
module test_isp_ctl_reg;

    localparam logic [7:0] KADR = 8'hF6;
    localparam logic [7:0] CADR = 8'hBF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic idle_wake = 1'b0;
    logic prog_en, boot_sel, auxram_en, prog_entry, swrst_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Reference model state
    int m_stage = 0;
    bit m_pen = 0, m_sel = 0, m_aux = 0, m_act = 0, m_entry = 0, m_swr = 0;

    always #2 clk = ~clk;

    isp_ctl_reg i_isp_ctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_wake(idle_wake),
        .prog_en(prog_en), .boot_sel(boot_sel), .auxram_en(auxram_en),
        .prog_entry(prog_entry), .swrst_pulse(swrst_pulse)
    );

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        bit chit, khit, pen_old;
        cyc++;
        chit = bus_wr && bus_addr == CADR && m_stage == 2;
        khit = bus_wr && bus_addr == KADR;
        pen_old = m_pen;
        m_swr = 0;
        m_entry = 0;
        if (!rst_n) begin
            m_stage = 0; m_pen = 0; m_sel = 0; m_aux = 0; m_act = 0;
        end else if (chit && bus_wdata[0] && bus_wdata[1] && bus_wdata[7]) begin
            m_stage = 0; m_pen = 0; m_sel = 0; m_aux = 0; m_act = 0; m_swr = 1;
        end else begin
            if (idle_wake && pen_old) begin m_entry = 1; m_act = 1; end
            if (chit) begin
                m_pen = bus_wdata[0]; m_sel = bus_wdata[1]; m_aux = bus_wdata[4];
            end
            if (khit) begin
                if (bus_wdata == 8'h87) m_stage = 1;
                else if (bus_wdata == 8'h59) m_stage = (m_stage >= 1) ? 2 : 0;
                else m_stage = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        logic [7:0] v = 8'h00;
        if (bus_addr == CADR) begin
            v[0] = m_pen; v[1] = m_sel; v[4] = m_aux; v[7] = m_act && m_sel;
        end
        return v;
    endfunction

    // Compare all outputs to the model, then drive the next inputs.
    task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic wk);
        @(negedge clk);
        chk("R3 prog_en", {7'b0, prog_en}, {7'b0, m_pen});
        chk("R4 boot_sel", {7'b0, boot_sel}, {7'b0, m_sel});
        chk("R5 auxram_en", {7'b0, auxram_en}, {7'b0, m_aux});
        chk("R6 swrst_pulse", {7'b0, swrst_pulse}, {7'b0, m_swr});
        chk("R7 prog_entry", {7'b0, prog_entry}, {7'b0, m_entry});
        chk("R8 rdata", bus_rdata, exp_rd());
        bus_wr = wr; bus_addr = a; bus_wdata = d; idle_wake = wk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, CADR, 8'h00, 1'b0);
    endtask

    task automatic unlock();
        step(1'b1, KADR, 8'h87, 1'b0);
        step(1'b1, KADR, 8'h59, 1'b0);
    endtask

    // Direct scenario check against hand-computed values.
    task automatic direct(input string tag, input logic [7:0] exp);
        step(1'b0, CADR, 8'h00, 1'b0);
        #0;
        chk(tag, bus_rdata, exp);
    endtask

    // Watchdog
    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        direct("R8 reset readback", 8'h00);

        // R1: locked write ignored
        step(1'b1, CADR, 8'h13, 1'b0);
        direct("R1 locked write ignored", 8'h00);

        // R2: wrong orders stay locked
        step(1'b1, KADR, 8'h59, 1'b0);
        step(1'b1, CADR, 8'h10, 1'b0);
        direct("R2 key B alone", 8'h00);
        step(1'b1, KADR, 8'h87, 1'b0);
        step(1'b1, KADR, 8'h00, 1'b0);
        step(1'b1, KADR, 8'h59, 1'b0);
        step(1'b1, CADR, 8'h10, 1'b0);
        direct("R2 broken sequence", 8'h00);

        // R2..R5, R9: open, write, reserved bits dropped
        unlock();
        step(1'b1, CADR, 8'h7F, 1'b0);
        direct("R9 reserved bits read 0", 8'h13);
        step(1'b1, CADR, 8'h12, 1'b0);
        direct("R2 stays open after write", 8'h12);
        step(1'b1, KADR, 8'h59, 1'b0);
        step(1'b1, CADR, 8'h02, 1'b0);
        direct("R2 key B keeps open", 8'h02);

        // R2: other value closes
        step(1'b1, KADR, 8'h33, 1'b0);
        step(1'b1, CADR, 8'h11, 1'b0);
        direct("R2 closed by other value", 8'h02);
        unlock();
        step(1'b1, KADR, 8'h87, 1'b0);
        step(1'b1, CADR, 8'h11, 1'b0);
        direct("R2 key A recloses", 8'h02);

        // R7: wake without enable, then with enable
        unlock();
        step(1'b1, CADR, 8'h02, 1'b1);
        step(1'b0, CADR, 8'h00, 1'b1);
        direct("R7 no entry without enable", 8'h02);
        step(1'b1, CADR, 8'h03, 1'b0);
        step(1'b0, CADR, 8'h00, 1'b1);
        direct("R7 entered, R8 bit7 boot bank", 8'h83);

        // R10: wake with a write that clears enable uses old enable
        step(1'b1, CADR, 8'h00, 1'b1);
        direct("R10 write applied after wake", 8'h00);
        step(1'b1, CADR, 8'h11, 1'b0);
        step(1'b0, CADR, 8'h00, 1'b1);
        direct("R4 bit7 low with sel 0", 8'h11);

        // R6: software reset, and R10 reset wins over wake
        step(1'b1, CADR, 8'h83, 1'b1);
        step(1'b0, CADR, 8'h00, 1'b0);
        #0;
        chk("R6 pulse seen", {7'b0, swrst_pulse}, 8'h01);
        chk("R10 no entry on reset", {7'b0, prog_entry}, 8'h00);
        chk("R6 cleared", bus_rdata, 8'h00);
        step(1'b1, CADR, 8'h10, 1'b0);
        direct("R6 key state cleared", 8'h00);
        idle(2);

        // R6 pattern while locked does nothing
        step(1'b1, CADR, 8'h83, 1'b0);
        step(1'b0, CADR, 8'h00, 1'b0);
        #0;
        chk("R1 locked reset pattern", {7'b0, swrst_pulse}, 8'h00);
        step(1'b0, 8'h20, 8'h00, 1'b0);
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule